// File: doc/BRIEF.md
# Paged Control Register Port

This block is the register front end of a larger chip. A host processor reaches it through a 16-bit data path and a 6-bit address. Chip-select, read and write strobes are all active high. The address space is split into two halves. The upper half (addresses 32 to 63) selects global registers directly, whatever page is active. The lower half (addresses 0 to 31) is a window onto a larger paged bank, and a page register decides which physical row the window shows.

The page register is global address 32. Global address 33 returns a status word taken live from an input port. Every other global location is plain read/write storage. The bidirectional data bus is split into an input path, an output path and an output-enable. The pad-level tri-state buffer sits outside the block and is driven by `data_oe`.

Top module: `pgreg_port`

## Requirements
- R1: After a synchronous active-high reset, every writable global and paged register reads 0, and the page register reads 0.
- R2: A write happens on the rising clock edge when `cs` and `wr` are both 1. A later read of the same global address (34 to 63) returns the written value.
- R3: Global addresses 32 to 63 reach the same storage whatever the page register holds.
- R4: Addresses 0 to 31 reach physical register `page*32 + addr`. The same offset on different pages holds independent values.
- R5: Global address 32 is the page register. Only data bits 2:0 are stored. A read returns those 3 bits in bits 2:0, with bits 15:3 equal to 0.
- R6: A page-register write takes effect from the next access onward. Paged accesses made before that edge use the old page.
- R7: A read of global address 33 returns `status_in` in the same cycle. A write to address 33 changes no register.
- R8: `data_oe` is 1 exactly when `cs` and `rd` are both 1. While it is 1, `data_out` holds the content of the addressed register. While it is 0, `data_out` is 0.
- R9: With `cs` low, `wr` changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 6 | Register address |
| data_in | input | 16 | Write data from the host bus |
| data_out | output | 16 | Read data toward the host bus |
| data_oe | output | 1 | Enable for the external bus driver |
| status_in | input | 16 | Live status word returned at address 33 |

## Verification
A corrupted page register shows up on the very next paged read as the value of another page's row. Its own readback at address 32 also shows the wrong page at once. A write that lands in the wrong row, or is lost, stays hidden until that location is read back. For this reason the random traffic reads every address often, and writes to the same offset on several pages. A wrong output-enable is visible in the same cycle as the strobe.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  // Class of the addressed location after decode
  typedef enum logic [1:0] {
    SEL_PAGED  = 2'd0,
    SEL_PAGE   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_GLOBAL = 2'd3
  } sel_e;

endpackage

// File: rtl/pgreg_decode.sv
module pgreg_decode
  import pgreg_pkg::*;
#(
  parameter int AW       = 6,
  parameter int PAGE_OFS = 0,
  parameter int STAT_OFS = 1,
  localparam int OW      = AW - 1
) (
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output logic [OW-1:0] offset,
  output logic          rd_en,
  output logic          we_paged,
  output logic          we_global,
  output logic          we_page
);

  logic wr_en;

  always_comb begin
    offset = addr[OW-1:0];
    if (!addr[AW-1])                  sel = SEL_PAGED;
    else if (offset == OW'(PAGE_OFS)) sel = SEL_PAGE;
    else if (offset == OW'(STAT_OFS)) sel = SEL_STATUS;
    else                              sel = SEL_GLOBAL;
  end

  assign rd_en     = cs & rd;
  assign wr_en     = cs & wr;
  assign we_paged  = wr_en && (sel == SEL_PAGED);
  assign we_global = wr_en && (sel == SEL_GLOBAL);
  assign we_page   = wr_en && (sel == SEL_PAGE);

endmodule

// File: rtl/pgreg_global_bank.sv
module pgreg_global_bank #(
  parameter int DW = 16,
  parameter int OW = 5,
  localparam int DEPTH = 1 << OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[offset] <= wdata;
    end
  end

  assign rdata = mem[offset];

endmodule

// File: rtl/pgreg_paged_bank.sv
module pgreg_paged_bank #(
  parameter int DW = 16,
  parameter int OW = 5,
  parameter int PW = 3,
  localparam int IW    = OW + PW,
  localparam int DEPTH = 1 << IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] page,
  input  logic [OW-1:0] offset,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];
  logic [IW-1:0] idx;

  // Physical row = page * window size + offset
  assign idx = {page, offset};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/pgreg_port.sv
module pgreg_port
  import pgreg_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int PW = 3,
  localparam int OW = AW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  input  logic [DW-1:0] status_in
);

  sel_e          sel;
  logic [OW-1:0] offset;
  logic          rd_en, we_paged, we_global, we_page;
  logic [PW-1:0] page_q;
  logic [DW-1:0] glob_rdata, paged_rdata, mux_rdata;

  pgreg_decode #(.AW(AW), .PAGE_OFS(0), .STAT_OFS(1)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .sel(sel), .offset(offset), .rd_en(rd_en),
    .we_paged(we_paged), .we_global(we_global), .we_page(we_page)
  );

  // Page register: the new value is used from the next access onward
  always_ff @(posedge clk) begin
    if (rst)          page_q <= '0;
    else if (we_page) page_q <= data_in[PW-1:0];
  end

  pgreg_global_bank #(.DW(DW), .OW(OW)) u_glob (
    .clk(clk), .rst(rst), .we(we_global), .offset(offset),
    .wdata(data_in), .rdata(glob_rdata)
  );

  pgreg_paged_bank #(.DW(DW), .OW(OW), .PW(PW)) u_paged (
    .clk(clk), .rst(rst), .we(we_paged), .page(page_q), .offset(offset),
    .wdata(data_in), .rdata(paged_rdata)
  );

  always_comb begin
    case (sel)
      SEL_PAGED:  mux_rdata = paged_rdata;
      SEL_PAGE:   mux_rdata = {{(DW-PW){1'b0}}, page_q};
      SEL_STATUS: mux_rdata = status_in;
      default:    mux_rdata = glob_rdata;
    endcase
  end

  assign data_oe  = rd_en;
  assign data_out = rd_en ? mux_rdata : '0;

endmodule

// File: rtl/pgreg_port_chk.sv
module pgreg_port_chk #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int PW = 3,
  localparam logic [AW-1:0] A_PAGE = AW'(1 << (AW - 1)),
  localparam logic [AW-1:0] A_STAT = A_PAGE + AW'(1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] data_in,
  input logic [DW-1:0] data_out,
  input logic          data_oe,
  input logic [DW-1:0] status_in
);

  // R8: the bus is released whenever the read strobe pair is absent
  p_bus_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |-> (!data_oe && data_out == '0));

  // R8: the bus is driven while chip-select and read are both active
  p_bus_drive_r8: assert property (@(posedge clk) disable iff (rst)
    (cs && rd) |-> data_oe);

  // R7: the status location reflects the input port
  p_status_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == A_STAT) |-> data_out == status_in);

  // R5: only the page bits can be nonzero in the page register readback
  p_page_width_r5: assert property (@(posedge clk) disable iff (rst)
    (cs && rd && addr == A_PAGE) |-> data_out[DW-1:PW] == '0);

  // R2: a global write is visible on a read of the same address one cycle later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cs && wr && !rd) && $past(addr) > A_STAT
      && cs && rd && addr == $past(addr))
    |-> data_out == $past(data_in));

  // R9: with no write enabled, repeated reads of one address are stable
  p_hold_without_write_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cs && rd && !(cs && wr)) && cs && rd
      && $stable(addr) && addr != A_STAT)
    |-> $stable(data_out));

endmodule

bind pgreg_port pgreg_port_chk #(.AW(AW), .DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
  .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
  .status_in(status_in)
);

// File: tb/pgreg_port_bench.sv
module pgreg_port_bench;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data_in = '0;
  logic [DW-1:0] data_out;
  logic          data_oe;
  logic [DW-1:0] status_in = 16'h0000;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [DW-1:0] m_glob  [64];
  logic [DW-1:0] m_paged [256];
  logic [PW-1:0] m_page;

  always #10 clk = ~clk;  // 50 MHz

  pgreg_port #(.AW(AW), .DW(DW), .PW(PW)) u_pgreg_port (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .status_in(status_in)
  );

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    if (a < 32)       return m_paged[{m_page, a[4:0]}];
    else if (a == 32) return {13'd0, m_page};
    else if (a == 33) return status_in;
    else              return m_glob[a];
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [DW-1:0] d);
    if (a < 32)       m_paged[{m_page, a[4:0]}] = d;
    else if (a == 32) m_page = d[PW-1:0];
    else if (a != 33) m_glob[a] = d;
  endfunction

  task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; rd = 1'b0; addr = a; data_in = d;
    @(negedge clk);
    if (sel) model_write(a, d);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, string tag);
    logic [DW-1:0] e;
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = a;
    #5;
    e = exp_read(a);
    check(data_oe === 1'b1, "R8", {15'd0, data_oe}, 16'd1);
    check(data_out === e, tag, data_out, e);
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++)  m_glob[i] = '0;
    for (int i = 0; i < 256; i++) m_paged[i] = '0;
    m_page = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    do_read(6'd32, "R1");
    do_read(6'd0,  "R1");
    do_read(6'd31, "R1");
    do_read(6'd63, "R1");
    // R8: bus idle with cs high and no read
    @(negedge clk); cs = 1'b1; #5;
    check(data_oe === 1'b0 && data_out === '0, "R8", data_out, 16'd0);
    cs = 1'b0; rd = 1'b1; #1;
    check(data_oe === 1'b0, "R8", {15'd0, data_oe}, 16'd0);
    rd = 1'b0;

    // R2: global write/read
    do_write(6'd34, 16'hA5C3);
    do_write(6'd63, 16'h0F0F);
    do_read(6'd34, "R2");
    do_read(6'd63, "R2");

    // R7: status passthrough, writes ignored
    status_in = 16'hBEEF;
    do_read(6'd33, "R7");
    do_write(6'd33, 16'h1234);
    status_in = 16'h5A5A;
    do_read(6'd33, "R7");
    do_read(6'd34, "R7");
    do_read(6'd32, "R7");

    // R9: write without chip-select
    do_write(6'd40, 16'hDEAD, 1'b0);
    do_write(6'd5,  16'hDEAD, 1'b0);
    do_read(6'd40, "R9");
    do_read(6'd5,  "R9");

    // R5: page register width
    do_write(6'd32, 16'hFFFD);
    do_read(6'd32, "R5");

    // R4/R6: same offset across pages, page change applies next access
    for (int p = 0; p < 8; p++) begin
      do_write(6'd32, 16'(p));
      do_write(6'd7, 16'(16'h1100 + p));
    end
    for (int p = 7; p >= 0; p--) begin
      do_write(6'd32, 16'(p));
      do_read(6'd7, "R6");
      do_read(6'd7, "R4");
      // R3: global unaffected by page
      do_read(6'd34, "R3");
    end

    // Random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [DW-1:0] e;
      @(negedge clk);
      cs      = ($urandom % 8) != 0;
      rd      = $urandom % 2;
      wr      = $urandom % 2;
      addr    = (($urandom % 4) == 0) ? 6'd32 : 6'($urandom);
      data_in = 16'($urandom);
      if (($urandom % 16) == 0) status_in = 16'($urandom);
      #5;
      if (cs && rd) begin
        e = exp_read(addr);
        check(data_out === e, "R4", data_out, e);
      end
      check(data_oe === (cs && rd), "R8", {15'd0, data_oe}, {15'd0, cs && rd});
      @(posedge clk);
      #1;
      if (cs && wr) model_write(addr, data_in);
    end
    @(negedge clk); cs = 0; rd = 0; wr = 0;

    // R1: reset again clears everything
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++)  m_glob[i] = '0;
    for (int i = 0; i < 256; i++) m_paged[i] = '0;
    m_page = '0;
    do_read(6'd32, "R1");
    do_read(6'd50, "R1");
    do_read(6'd7,  "R1");

    finish_run();
  end

endmodule